// File: doc/BRIEF.md
# Four-Phase Handshake Link Between Unrelated Clock Domains

This block carries parallel data words from a sending device to a receiving device when the two run on clocks with no fixed relation. Two handshake lines and a shared data bus connect the two sides. The forward line is driven by the sender and the return line by the receiver. Every transfer is return-to-zero: both lines go high in turn, then both go low again, before the next word may start.

The sender side takes words from a local valid/ready input. It places each word on the bus and runs the handshake from its own clock. The receiver side captures the word and holds it on a local valid/ready output until it is taken. Each line passes through a multi-flop synchronizer before the far state machine uses it. A static mode input picks who starts a transfer. In push mode the sender raises the forward line as a request and the receiver answers on the return line as an acknowledge. In pull mode the receiver raises the return line as a strobe and the sender answers on the forward line as a data-ready. Each side has a cycle-count limit. When the far side stays silent too long, that side sets a sticky timeout flag.

Top module: `hs_link`

## Requirements
- R1: Push mode (`pull_mode`=0). The forward line rises with the word on the bus. The return line rises only after the receiver captured the word. The forward line falls only while the sender still sees the return line high. The return line falls only after the receiver sees the forward line low.
- R2: Pull mode (`pull_mode`=1). The receiver raises the return line when its output is empty. The forward line rises only while the sender sees the return line high. The receiver captures the word on seeing the forward line high, then lowers the return line. The sender lowers the forward line after seeing the return line low.
- R3: The bus word is loaded at least one sender cycle before the forward line rises. It stays unchanged for as long as the forward line is high.
- R4: A new transfer does not start until both lines are low. When the link is idle, both lines read 0.
- R5: Once `d_valid` is 1, `d_valid` and `d_data` hold until a cycle with `d_ready`=1.
- R6: Every word accepted on the `s_valid`/`s_ready` side comes out on `d_data` exactly once and in order, in both modes.
- R7: In push mode `s_ready` is 1 only when the sender is idle and sees the return line low. In pull mode it is 1 only when the sender is idle and sees the strobe. So `s_ready` is 1 after reset in push mode and 0 during reset in pull mode.
- R8: A side that waits on the far side for more than `tmo_limit` of its own cycles sets its timeout flag. The flag stays set until reset. A limit of 0 disables the flag.
- R9: During and right after reset, both lines are low, `d_valid` is 0 and both timeout flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Sender clock |
| rst_s_n | input | 1 | Sender reset, active low, asynchronous assert |
| clk_d | input | 1 | Receiver clock |
| rst_d_n | input | 1 | Receiver reset, active low, asynchronous assert |
| pull_mode | input | 1 | 0 = push, 1 = pull; changed only under reset |
| tmo_limit | input | TW | Timeout limit in local cycles, 0 disables |
| s_valid | input | 1 | Sender-side word offered |
| s_data | input | W | Sender-side word |
| s_ready | output | 1 | Sender-side word accepted this cycle |
| d_valid | output | 1 | Receiver-side word held |
| d_data | output | W | Receiver-side word |
| d_ready | input | 1 | Receiver-side word taken |
| link_fwd | output | 1 | Forward handshake line (request or data-ready) |
| link_back | output | 1 | Return handshake line (acknowledge or strobe) |
| s_timeout | output | 1 | Sticky sender timeout flag |
| d_timeout | output | 1 | Sticky receiver timeout flag |

## Verification
Two things can fall in the same receiver cycle: the local consumer draining the held word, and the handshake trying to deliver the next one. In push mode the receiver must not capture while `d_valid` is still set. In pull mode it must not strobe until the output is empty. The bench drives `d_ready` at random on an unrelated clock so that a drain and a new forward edge often coincide. It then checks order and duplicates against a queue of accepted words. A directed case holds `d_ready` low across a second transfer, which must leave the sender waiting and raise only its timeout flag.

// File: rtl/hs_pkg.sv
package hs_pkg;
   typedef enum logic [1:0] {
      SRC_IDLE, SRC_SETUP, SRC_HOLD, SRC_DRAIN
   } src_state_t;

   typedef enum logic [1:0] {
      DST_IDLE, DST_STROBE, DST_RELEASE
   } dst_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("hs_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_timer.sv
module hs_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] limit,
   input  logic          wait_en,
   output logic          flag
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (!wait_en)         cnt <= '0;
         else if (cnt != '1)   cnt <= cnt + 1'b1;
         if (wait_en && limit != '0 && cnt >= limit) flag <= 1'b1;
      end
   end
endmodule

// File: rtl/hs_src_ctl.sv
module hs_src_ctl #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pull_mode,
   input  logic         back_in,
   input  logic         s_valid,
   input  logic [W-1:0] s_data,
   output logic         s_ready,
   output logic         fwd_out,
   output logic [W-1:0] bus_out,
   output logic         wait_out
);
   import hs_pkg::*;

   src_state_t st;
   logic       may_start;
   logic       answered;

   always_comb begin
      may_start = pull_mode ? back_in : !back_in;
      answered  = pull_mode ? !back_in : back_in;
      s_ready   = (st == SRC_IDLE) && may_start;
      wait_out  = (st == SRC_HOLD) || (st == SRC_DRAIN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SRC_IDLE;
         fwd_out <= 1'b0;
         bus_out <= '0;
      end else begin
         case (st)
            SRC_IDLE: if (s_valid && s_ready) begin
               bus_out <= s_data;
               st      <= SRC_SETUP;
            end
            SRC_SETUP: begin
               fwd_out <= 1'b1;
               st      <= SRC_HOLD;
            end
            SRC_HOLD: if (answered) begin
               fwd_out <= 1'b0;
               bus_out <= '0;
               st      <= SRC_DRAIN;
            end
            SRC_DRAIN: if (!back_in) st <= SRC_IDLE;
            default: st <= SRC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hs_dst_ctl.sv
module hs_dst_ctl #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pull_mode,
   input  logic         fwd_in,
   input  logic [W-1:0] bus_in,
   output logic         back_out,
   output logic         d_valid,
   output logic [W-1:0] d_data,
   input  logic         d_ready,
   output logic         wait_out
);
   import hs_pkg::*;

   dst_state_t st;

   assign wait_out = (st == DST_STROBE) || (st == DST_RELEASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= DST_IDLE;
         back_out <= 1'b0;
         d_valid  <= 1'b0;
         d_data   <= '0;
      end else begin
         if (d_valid && d_ready) d_valid <= 1'b0;
         case (st)
            DST_IDLE: begin
               if (!pull_mode && fwd_in && !d_valid) begin
                  d_data   <= bus_in;
                  d_valid  <= 1'b1;
                  back_out <= 1'b1;
                  st       <= DST_RELEASE;
               end else if (pull_mode && !fwd_in && !d_valid) begin
                  back_out <= 1'b1;
                  st       <= DST_STROBE;
               end
            end
            DST_STROBE: if (fwd_in) begin
               d_data   <= bus_in;
               d_valid  <= 1'b1;
               back_out <= 1'b0;
               st       <= DST_RELEASE;
            end
            DST_RELEASE: if (!fwd_in) begin
               back_out <= 1'b0;
               st       <= DST_IDLE;
            end
            default: st <= DST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hs_link.sv
module hs_link #(
   parameter int W           = 16,
   parameter int TW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk_s,
   input  logic          rst_s_n,
   input  logic          clk_d,
   input  logic          rst_d_n,
   input  logic          pull_mode,
   input  logic [TW-1:0] tmo_limit,
   input  logic          s_valid,
   input  logic [W-1:0]  s_data,
   output logic          s_ready,
   output logic          d_valid,
   output logic [W-1:0]  d_data,
   input  logic          d_ready,
   output logic          link_fwd,
   output logic          link_back,
   output logic          s_timeout,
   output logic          d_timeout
);
   if (W < 1 || TW < 1) begin : g_bad_width
      $error("hs_link: W and TW must be positive");
   end

   logic         fwd_at_d;
   logic         back_at_s;
   logic [W-1:0] bus;
   logic         s_wait;
   logic         d_wait;

   hs_sync #(.STAGES(SYNC_STAGES)) u_sync_fwd (
      .clk(clk_d), .rst_n(rst_d_n), .d(link_fwd), .q(fwd_at_d));

   hs_sync #(.STAGES(SYNC_STAGES)) u_sync_back (
      .clk(clk_s), .rst_n(rst_s_n), .d(link_back), .q(back_at_s));

   hs_src_ctl #(.W(W)) u_src (
      .clk(clk_s), .rst_n(rst_s_n), .pull_mode(pull_mode),
      .back_in(back_at_s), .s_valid(s_valid), .s_data(s_data),
      .s_ready(s_ready), .fwd_out(link_fwd), .bus_out(bus),
      .wait_out(s_wait));

   hs_dst_ctl #(.W(W)) u_dst (
      .clk(clk_d), .rst_n(rst_d_n), .pull_mode(pull_mode),
      .fwd_in(fwd_at_d), .bus_in(bus), .back_out(link_back),
      .d_valid(d_valid), .d_data(d_data), .d_ready(d_ready),
      .wait_out(d_wait));

   hs_timer #(.TW(TW)) u_tmo_s (
      .clk(clk_s), .rst_n(rst_s_n), .limit(tmo_limit),
      .wait_en(s_wait), .flag(s_timeout));

   hs_timer #(.TW(TW)) u_tmo_d (
      .clk(clk_d), .rst_n(rst_d_n), .limit(tmo_limit),
      .wait_en(d_wait), .flag(d_timeout));
endmodule

// File: rtl/hs_link_chk.sv
module hs_link_chk #(
   parameter int W = 16
) (
   input logic         clk_s,
   input logic         rst_s_n,
   input logic         clk_d,
   input logic         rst_d_n,
   input logic         pull_mode,
   input logic         link_fwd,
   input logic         link_back,
   input logic         fwd_at_d,
   input logic         back_at_s,
   input logic [W-1:0] bus,
   input logic         s_valid,
   input logic         s_ready,
   input logic         d_valid,
   input logic         d_ready,
   input logic [W-1:0] d_data,
   input logic         s_timeout,
   input logic         d_timeout
);
   a_r1_fwd_falls_on_ack: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      (!pull_mode && $fell(link_fwd)) |-> back_at_s);

   a_r1_ack_falls_after_req: assert property (@(posedge clk_d) disable iff (!rst_d_n)
      (!pull_mode && $fell(link_back)) |-> !fwd_at_d);

   a_r2_ready_answers_strobe: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      (pull_mode && $rose(link_fwd)) |-> back_at_s);

   a_r3_bus_stable: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      link_fwd |-> $stable(bus));

   a_r4_push_start_idle: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      (!pull_mode && $rose(link_fwd)) |-> !back_at_s);

   a_r4_pull_start_idle: assert property (@(posedge clk_d) disable iff (!rst_d_n)
      (pull_mode && $rose(link_back)) |-> !fwd_at_d);

   a_r7_accept_idle: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      (s_valid && s_ready) |-> !link_fwd);

   a_r5_hold_output: assert property (@(posedge clk_d) disable iff (!rst_d_n)
      (d_valid && !d_ready) |=> (d_valid && $stable(d_data)));

   a_r8_s_sticky: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      s_timeout |=> s_timeout);

   a_r8_d_sticky: assert property (@(posedge clk_d) disable iff (!rst_d_n)
      d_timeout |=> d_timeout);
endmodule

bind hs_link hs_link_chk #(.W(W)) u_chk (
   .clk_s(clk_s), .rst_s_n(rst_s_n), .clk_d(clk_d), .rst_d_n(rst_d_n),
   .pull_mode(pull_mode), .link_fwd(link_fwd), .link_back(link_back),
   .fwd_at_d(fwd_at_d), .back_at_s(back_at_s), .bus(bus),
   .s_valid(s_valid), .s_ready(s_ready), .d_valid(d_valid),
   .d_ready(d_ready), .d_data(d_data), .s_timeout(s_timeout),
   .d_timeout(d_timeout));

// File: tb/test_hs_link.sv
module test_hs_link;
   localparam int W  = 16;
   localparam int TW = 16;

   logic          clk_s = 1'b0, clk_d = 1'b0;
   logic          rst_s_n = 1'b0, rst_d_n = 1'b0;
   logic          pull_mode = 1'b0;
   logic [TW-1:0] tmo_limit = '0;
   logic          s_valid = 1'b0;
   logic [W-1:0]  s_data = '0;
   logic          s_ready, d_valid, link_fwd, link_back, s_timeout, d_timeout;
   logic [W-1:0]  d_data;
   logic          d_ready = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] exp_q[$];

   always #10 clk_s = ~clk_s;   // 50 MHz
   always #17 clk_d = ~clk_d;   // unrelated receiver clock

   hs_link #(.W(W), .TW(TW)) i_hs_link (
      .clk_s(clk_s), .rst_s_n(rst_s_n), .clk_d(clk_d), .rst_d_n(rst_d_n),
      .pull_mode(pull_mode), .tmo_limit(tmo_limit),
      .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
      .d_valid(d_valid), .d_data(d_data), .d_ready(d_ready),
      .link_fwd(link_fwd), .link_back(link_back),
      .s_timeout(s_timeout), .d_timeout(d_timeout));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit coin(input int pct);
      return ($urandom % 100) < pct;
   endfunction

   task automatic do_reset(input logic mode, input logic [TW-1:0] lim);
      rst_s_n = 1'b0; rst_d_n = 1'b0;
      s_valid = 1'b0; d_ready = 1'b0;
      pull_mode = mode; tmo_limit = lim;
      exp_q.delete();
      repeat (4) @(negedge clk_d);
      chk("R9 fwd low in reset", link_fwd, 0);
      chk("R9 back low in reset", link_back, 0);
      chk("R9 d_valid low in reset", d_valid, 0);
      chk("R9 flags low in reset", {s_timeout, d_timeout}, 0);
      chk("R7 s_ready in reset", s_ready, !mode);
      @(negedge clk_s);
      rst_s_n = 1'b1; rst_d_n = 1'b1;
   endtask

   task automatic drive_src(input int n, input int pct);
      bit took = 0;
      for (int k = 0; k < n; ) begin
         @(negedge clk_s);
         if (took) begin s_valid = 1'b0; took = 0; end
         if (!s_valid && coin(pct)) begin
            s_valid = 1'b1;
            s_data  = W'($urandom);
         end
         #1;
         if (s_valid && s_ready) begin
            exp_q.push_back(s_data);
            k++;
            took = 1;
         end
      end
      @(negedge clk_s);
      s_valid = 1'b0;
   endtask

   task automatic drive_dst(input int n, input int pct);
      for (int got = 0; got < n; ) begin
         @(negedge clk_d);
         d_ready = coin(pct);
         #1;
         if (d_valid && d_ready) begin
            if (exp_q.size() == 0) chk("R6 no extra word", 1, 0);
            else chk("R6 word order", d_data, exp_q.pop_front());
            got++;
         end
      end
      @(negedge clk_d);
      d_ready = 1'b0;
   endtask

   task automatic run(input int n, input int pv, input int pr);
      fork
         drive_src(n, pv);
         drive_dst(n, pr);
      join
   endtask

   initial begin
      repeat (150000) @(posedge clk_s);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd1517));

      // push mode, random traffic, timeout disabled
      do_reset(1'b0, '0);
      @(negedge clk_s);
      chk("R7 push s_ready after reset", s_ready, 1);
      run(60, 70, 55);
      chk("R6 push all delivered", exp_q.size(), 0);
      repeat (20) @(negedge clk_s);
      chk("R4 push idle lines", {link_fwd, link_back}, 0);
      chk("R8 limit zero disables", {s_timeout, d_timeout}, 0);
      chk("R1 push output drained", d_valid, 0);

      // pull mode, random traffic
      do_reset(1'b1, '0);
      run(60, 60, 65);
      chk("R6 pull all delivered", exp_q.size(), 0);
      repeat (20) @(negedge clk_s);
      chk("R2 pull strobe waits for data", link_back, 1);
      chk("R4 pull forward low when idle", link_fwd, 0);

      // pull mode, sender silent: receiver times out
      do_reset(1'b1, TW'(20));
      repeat (100) @(negedge clk_s);
      chk("R2 strobe raised on empty output", link_back, 1);
      chk("R7 pull s_ready on strobe", s_ready, 1);
      chk("R8 receiver timeout set", d_timeout, 1);
      chk("R8 sender timeout clear", s_timeout, 0);
      run(1, 100, 100);
      chk("R6 pull late word delivered", exp_q.size(), 0);
      chk("R8 receiver timeout sticky", d_timeout, 1);

      // push mode, receiver stalled: sender times out
      do_reset(1'b0, TW'(30));
      drive_src(2, 100);
      repeat (150) @(negedge clk_s);
      chk("R5 first word held", d_valid, 1);
      chk("R5 first word value", d_data, exp_q[0]);
      chk("R3 request held while unanswered", link_fwd, 1);
      chk("R8 sender timeout set", s_timeout, 1);
      chk("R8 receiver timeout clear", d_timeout, 0);
      drive_dst(2, 100);
      chk("R8 sender timeout sticky", s_timeout, 1);
      repeat (20) @(negedge clk_s);
      chk("R4 lines low after stall", {link_fwd, link_back}, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule